// File: doc/BRIEF.md
# Break Field Receive Detector

This block sits next to a UART receiver and recognises a break field: a long low period on the serial receive line. Software arms it with a one-cycle trigger while the receiver is powered and enabled. The block then waits for a falling edge on the synchronised line and counts bit times with the baud tick while the line stays low. When the line goes high again, it compares the measured width with a minimum.

A break that is long enough raises a one-cycle receive-complete interrupt and clears the armed flag. A break that is too short produces no interrupt, and the block waits for the next falling edge with the flag still set. During the measurement and in the completion cycle, the block drives a hold signal. The hold signal tells the normal receive path not to update its error flags (overrun, parity, framing) and not to move shifted data into the receive data register, which therefore keeps its reset value of 0xFF.

Top module: `brk_rx_detect`

## Requirements
- R1: After reset, `armed`, `rx_irq` and `upd_hold` are all 0.
- R2: A high `arm_trig` in a cycle where `pwr_en` and `rx_en` are both 1 and the block is idle sets `armed` from the next cycle. `arm_trig` has no effect while either enable is 0.
- R3: `rx` passes through a two-stage synchroniser. A falling edge of the synchronised line while armed and waiting starts a measurement. `upd_hold` is 1 for as long as the measurement lasts.
- R4: During a measurement, the width count goes up by one for each cycle with `baud_tick` = 1. A tick in the same cycle as the rising edge of the synchronised line is not counted.
- R5: A rising edge with a count of at least MIN_BITS (default 11) produces exactly one cycle of `rx_irq` = 1. `armed` goes to 0 in that same cycle.
- R6: A rising edge with a count below MIN_BITS (10 or fewer by default) produces no `rx_irq`. `armed` stays 1 and the block waits for another falling edge.
- R7: The width count saturates at its maximum value rather than wrapping, so a break much longer than the counter range is still accepted as valid.
- R8: When `pwr_en` or `rx_en` is 0 at a clock edge, the block goes idle. `armed` is 0 from the next cycle and no `rx_irq` is produced for a break that was in progress.
- R9: `upd_hold` is 1 exactly during a measurement and in the `rx_irq` cycle, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Receiver power enable |
| rx_en | input | 1 | Receiver enable |
| arm_trig | input | 1 | One-cycle request to arm break reception |
| baud_tick | input | 1 | One pulse per bit time |
| rx | input | 1 | Asynchronous serial receive line, idle high |
| armed | output | 1 | Break reception is armed (waiting or measuring) |
| rx_irq | output | 1 | One-cycle receive-complete interrupt for a valid break |
| upd_hold | output | 1 | Blocks error-flag and data-register updates in the normal receiver |

## Verification
A wrong state register shows up at once on `armed` or `upd_hold`, because both are decoded from the state and the reference model compares them on every clock. A width count that is wrong, or that wraps instead of saturating, only shows up when the line rises. It then appears as a missing or extra `rx_irq` at the 10/11-bit boundary, or at the end of a break far longer than the counter range. Edge detection that is off by one synchroniser stage moves the rise of `upd_hold` by one cycle, and the per-cycle comparison reports that cycle directly.

// File: rtl/brk_pkg.sv
package brk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_MEAS = 2'd2
   } brk_state_e;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s,
   output logic fall,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      genvar g;
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= IDLE_LVL;
               else        chain[0] <= line_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= IDLE_LVL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_LVL;
      else        prev <= chain[STAGES-1];
   end

   assign line_s = chain[STAGES-1];
   assign fall   = prev & ~line_s;
   assign rise   = ~prev & line_s;
endmodule

// File: rtl/brk_width_cnt.sv
module brk_width_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (inc && cnt != CNT_TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl
   import brk_pkg::*;
#(
   parameter int W        = 4,
   parameter int MIN_BITS = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         arm,
   input  logic         fall,
   input  logic         rise,
   input  logic         tick,
   input  logic [W-1:0] cnt,
   output logic         cnt_clr,
   output logic         cnt_inc,
   output logic         armed,
   output logic         irq,
   output logic         hold
);
   localparam logic [W-1:0] MIN_CNT = W'(MIN_BITS);

   brk_state_e st_q, st_d;
   logic       irq_d;

   always_comb begin
      st_d  = st_q;
      irq_d = 1'b0;
      if (!en) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (arm)  st_d = ST_WAIT;
            ST_WAIT: if (fall) st_d = ST_MEAS;
            ST_MEAS: begin
               if (rise) begin
                  if (cnt >= MIN_CNT) begin
                     irq_d = 1'b1;
                     st_d  = ST_IDLE;
                  end else begin
                     st_d = ST_WAIT;
                  end
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         irq  <= 1'b0;
      end else begin
         st_q <= st_d;
         irq  <= irq_d;
      end
   end

   assign cnt_clr = (st_q != ST_MEAS);
   assign cnt_inc = (st_q == ST_MEAS) && tick && !rise;
   assign armed   = (st_q != ST_IDLE);
   assign hold    = (st_q == ST_MEAS) || irq;
endmodule

// File: rtl/brk_rx_detect.sv
module brk_rx_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_BITS    = 11,
   parameter int CNT_W       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic rx_en,
   input  logic arm_trig,
   input  logic baud_tick,
   input  logic rx,
   output logic armed,
   output logic rx_irq,
   output logic upd_hold
);
   localparam int CNT_LIMIT = (1 << CNT_W) - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_BITS < 1 || MIN_BITS > CNT_LIMIT) begin : g_bad_min
         $error("MIN_BITS must fit in the width counter");
      end
   endgenerate

   logic         line_s, fall, rise;
   logic         cnt_clr, cnt_inc;
   logic [CNT_W-1:0] cnt;
   logic         en;

   assign en = pwr_en & rx_en;

   brk_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(rx),
      .line_s(line_s), .fall(fall), .rise(rise)
   );

   brk_width_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
   );

   brk_ctrl #(.W(CNT_W), .MIN_BITS(MIN_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .arm(arm_trig),
      .fall(fall), .rise(rise), .tick(baud_tick), .cnt(cnt),
      .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
      .armed(armed), .irq(rx_irq), .hold(upd_hold)
   );
endmodule

// File: rtl/brk_rx_detect_chk.sv
module brk_rx_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_en,
   input logic rx_en,
   input logic arm_trig,
   input logic armed,
   input logic rx_irq,
   input logic upd_hold
);
   assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   assert_irq_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> !armed);

   assert_irq_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(armed));

   assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_en && rx_en) |=> (!armed && !rx_irq));

   assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && arm_trig && pwr_en && rx_en) |=> armed);

   assert_hold_scope_R9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hold |-> (armed || rx_irq));
endmodule

bind brk_rx_detect brk_rx_detect_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
   .arm_trig(arm_trig), .armed(armed), .rx_irq(rx_irq), .upd_hold(upd_hold)
);

// File: tb/tb_brk_rx_detect.sv
`timescale 1ns/1ps
module tb_brk_rx_detect;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_en = 1'b0, rx_en = 1'b0, arm_trig = 1'b0, baud_tick = 1'b0, rx = 1'b1;
   logic armed, rx_irq, upd_hold;

   int total = 0, bad = 0, cyc = 0, irq_seen = 0, tick_ph = 0;
   bit done = 0;

   // reference model state
   bit m_s1 = 1, m_s2 = 1, m_d = 1, m_irq = 0;
   int m_st = 0, m_cnt = 0;

   always #10 clk = ~clk;

   brk_rx_detect dut (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
      .arm_trig(arm_trig), .baud_tick(baud_tick), .rx(rx),
      .armed(armed), .rx_irq(rx_irq), .upd_hold(upd_hold)
   );

   // behavioural model: idle=0 wait=1 measure=2, min width 11, count ceiling 15
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_d = 1; m_st = 0; m_cnt = 0; m_irq = 0;
      end else begin
         bit f, r, ni;
         f = m_d && !m_s2;
         r = !m_d && m_s2;
         ni = 0;
         if (!(pwr_en && rx_en)) begin
            m_st = 0; m_cnt = 0;
         end else if (m_st == 0) begin
            if (arm_trig) m_st = 1;
         end else if (m_st == 1) begin
            if (f) begin m_st = 2; m_cnt = 0; end
         end else begin
            if (r) begin
               if (m_cnt >= 11) begin ni = 1; m_st = 0; end
               else m_st = 1;
            end else if (baud_tick && m_cnt < 15) m_cnt++;
         end
         if (m_st != 2) m_cnt = 0;
         m_irq = ni;
         m_d = m_s2; m_s2 = m_s1; m_s1 = rx;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model, and free-running baud tick (1 in 4)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3/R9 armed vs model", armed, (m_st != 0));
         chk("R5 rx_irq vs model", rx_irq, m_irq);
         chk("R9 upd_hold vs model", upd_hold, (m_st == 2) || m_irq);
         if (rx_irq) irq_seen++;
      end
      tick_ph = (tick_ph + 1) % 4;
      baud_tick = (tick_ph == 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic arm();
      @(negedge clk); arm_trig = 1'b1;
      @(negedge clk); arm_trig = 1'b0;
   endtask

   task automatic brk(input int len);
      @(negedge clk); rx = 1'b0;
      repeat (len) @(negedge clk);
      rx = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset armed", armed, 0);
      chk("R1 reset irq", rx_irq, 0);
      chk("R1 reset hold", upd_hold, 0);

      // R2: arm ignored without rx_en
      pwr_en = 1'b1;
      arm();
      @(negedge clk);
      chk("R2 arm ignored while disabled", armed, 0);
      rx_en = 1'b1;
      arm();
      chk("R2 armed after trigger", armed, 1);

      // R3: hold during measurement
      irq_seen = 0;
      @(negedge clk); rx = 1'b0;
      repeat (6) @(negedge clk);
      chk("R3 hold during measurement", upd_hold, 1);
      repeat (38) @(negedge clk);   // total 44 low cycles = 11 counted ticks
      rx = 1'b1;
      repeat (8) @(negedge clk);
      chk("R4 R5 eleven-bit break gives one irq", irq_seen, 1);
      chk("R5 armed cleared after valid break", armed, 0);
      chk("R9 hold released after valid break", upd_hold, 0);

      // R6: ten-bit break is short
      arm();
      irq_seen = 0;
      brk(40);
      chk("R6 ten-bit break gives no irq", irq_seen, 0);
      chk("R6 still armed after short break", armed, 1);

      // R6 then valid break while still armed
      brk(60);
      chk("R6 re-wait then valid break", irq_seen, 1);

      // R7: very long break saturates
      arm();
      irq_seen = 0;
      brk(400);
      chk("R7 long break still valid", irq_seen, 1);

      // R8: drop rx_en mid-break
      arm();
      irq_seen = 0;
      @(negedge clk); rx = 1'b0;
      repeat (30) @(negedge clk);
      rx_en = 1'b0;
      repeat (30) @(negedge clk);
      rx = 1'b1;
      repeat (8) @(negedge clk);
      chk("R8 disable clears armed", armed, 0);
      chk("R8 no irq after disable", irq_seen, 0);

      // R8: power drop while waiting
      rx_en = 1'b1;
      arm();
      pwr_en = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R8 power drop clears armed", armed, 0);
      pwr_en = 1'b1;

      // R2: trigger while already armed keeps armed, valid break afterwards
      arm(); arm();
      irq_seen = 0;
      brk(48);
      chk("R2 R5 valid break after repeated trigger", irq_seen, 1);

      repeat (4) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule